// File: doc/BRIEF.md
# Ethernet Receive Frame Error Classifier

This block sits on a received Ethernet byte stream and grades each frame as it ends. The stream arrives as a bus of byte lanes. Lane 0 carries the earliest byte. Each beat comes with a valid strobe, start and end markers, a per-lane control flag and, on the last beat, a count of unused lanes. While a frame is in flight, the block keeps a running byte count and a CRC-32 register. It captures the length/type field from frame bytes 12 and 13, most significant byte first, and it remembers whether any bad control character was seen.

One cycle after the final beat, the block presents a six-bit error code and a separate FCS-error flag. The code keeps apart five faults: a bad control character, a checksum mismatch, a short frame, a long frame and a payload that disagrees with the length field. A fragment of eight bytes or fewer is not treated as a frame and produces no report. Two settings can be written: the size ceiling for long frames (address 0) and the enable for the length check (address 1, bit 0).

The control path is a two-state machine. `S_IDLE` waits for a start marker. `S_FRAME` collects a frame. The transitions are:
- open: `S_IDLE` to `S_FRAME` on a valid start beat without an end marker.
- close: `S_FRAME` to `S_IDLE` on a valid end beat.
- restart: `S_FRAME` to `S_FRAME` on a valid start beat without an end marker. This drops the partial frame.
- one-beat frame: a start beat that also carries the end marker in `S_IDLE` is graded without leaving `S_IDLE`.

Top module: `rxerr_classifier`

## Requirements
- R1: `rpt_valid` pulses for exactly one cycle, in the cycle after the valid end beat of a frame. Beats that arrive in `S_IDLE` without a start marker are ignored and produce no report.
- R2: Bit 0 of `rpt_err` is set when a used lane inside the frame has its control flag high and a byte other than the terminate code 0xFD. A flagged lane that holds 0xFD does not set bit 0.
- R3: The CRC-32 runs reflected, with polynomial 0x04C11DB7 and a start value of all ones, over every byte from the destination address through the FCS. The frame passes when the register equals the good-frame residue, 0xC704DD7B in bit-reversed form (0xDEBB20E3 as held). A mismatch sets bit 1 and `rpt_fcs_err`. Bit 1 and `rpt_fcs_err` are always equal.
- R4: A frame of 9 to 63 bytes sets bit 2, and it also sets bit 1 and `rpt_fcs_err`. A 64-byte frame does not set bit 2.
- R5: A sequence of 8 bytes or fewer produces no report: `rpt_valid` stays low.
- R6: Bit 4 is set only when the length check is enabled (address 1, bit 0 = 1) and the length/type field is below 1536. It is set when frame size minus 18 differs from the field. A field below 46 instead requires a frame of exactly 64 bytes. A frame under 18 bytes always mismatches.
- R7: Bit 3 is set when the frame size is greater than the size ceiling. The ceiling resets to 1518 and is written at address 0.
- R8: Bit 5 of `rpt_err` is always 0.
- R9: A start beat in the middle of a frame discards the partial frame and begins a new count, CRC and field capture.
- R10: On the end beat, only the lowest NLANE minus `in_empty` lanes count toward size, CRC and field capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat strobe |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | 8*NLANE | Byte lanes, lane 0 earliest |
| in_ctl | input | NLANE | Per-lane control-character flag |
| in_empty | input | $clog2(NLANE) | Unused upper lanes on the end beat |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 1 | 0: size ceiling, 1: length-check enable |
| cfg_wdata | input | SIZE_W | Write value |
| rpt_valid | output | 1 | Report strobe |
| rpt_err | output | 6 | Error code: bit 0 control, bit 1 CRC, bit 2 short, bit 3 long, bit 4 length, bit 5 zero |
| rpt_fcs_err | output | 1 | FCS-error flag |

## Verification
The end beat is sampled at one rising edge, and the report registers load at that same edge. `rpt_valid`, `rpt_err` and `rpt_fcs_err` therefore belong to the cycle that follows the end beat. A setting write takes effect for every end beat that is sampled after the write edge. The bench drives each beat on a falling edge. After the end beat has been captured, it reads the report at the very next falling edge, half a cycle after the report registers load. Cases with no report read `rpt_valid` at that same point.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

    typedef enum logic {S_IDLE, S_FRAME} rx_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_GOOD_REG  = 32'hDEBB20E3;
    localparam logic [7:0]  TERM_CODE     = 8'hFD;
    localparam int LEN_TYPE_LIMIT = 1536;
    localparam int MIN_FRAME      = 64;
    localparam int RUNT_MAX       = 8;
    localparam int HDR_FCS_BYTES  = 18;
    localparam int MIN_PAYLOAD    = 46;
    localparam int LT_POS         = 12;

    localparam int EB_CTL  = 0;
    localparam int EB_CRC  = 1;
    localparam int EB_RUNT = 2;
    localparam int EB_LONG = 3;
    localparam int EB_PLEN = 4;

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxerr_crc.sv
module rxerr_crc
    import rxerr_pkg::*;
#(
    parameter int NLANE = 4
) (
    input  logic [31:0]        crc_in,
    input  logic [8*NLANE-1:0] data,
    input  logic [NLANE-1:0]   lane_en,
    output logic [31:0]        crc_out
);

    always_comb begin
        logic [31:0] r;
        r = crc_in;
        for (int l = 0; l < NLANE; l++) begin
            if (lane_en[l]) r = crc_byte(r, data[8*l +: 8]);
        end
        crc_out = r;
    end

endmodule

// File: rtl/rxerr_lanes.sv
module rxerr_lanes
    import rxerr_pkg::*;
#(
    parameter int NLANE  = 4,
    parameter int SIZE_W = 16
) (
    input  logic [SIZE_W-1:0]  base_cnt,
    input  logic [8*NLANE-1:0] data,
    input  logic [NLANE-1:0]   ctl,
    input  logic [NLANE-1:0]   lane_en,
    input  logic [15:0]        lt_in,
    output logic [15:0]        lt_out,
    output logic               bad_ctl
);

    logic [NLANE-1:0] lane_bad;

    generate
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            assign lane_bad[l] = lane_en[l] & ctl[l] & (data[8*l +: 8] != TERM_CODE);
        end
    endgenerate

    assign bad_ctl = |lane_bad;

    always_comb begin
        logic [SIZE_W-1:0] pos;
        lt_out = lt_in;
        for (int l = 0; l < NLANE; l++) begin
            pos = base_cnt + SIZE_W'(l);
            if (lane_en[l] && pos == SIZE_W'(LT_POS))     lt_out[15:8] = data[8*l +: 8];
            if (lane_en[l] && pos == SIZE_W'(LT_POS + 1)) lt_out[7:0]  = data[8*l +: 8];
        end
    end

endmodule

// File: rtl/rxerr_cfg.sv
module rxerr_cfg #(
    parameter int SIZE_W      = 16,
    parameter int MAX_DEFAULT = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [SIZE_W-1:0] cfg_wdata,
    output logic [SIZE_W-1:0] max_size,
    output logic              len_chk_en
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_size   <= SIZE_W'(MAX_DEFAULT);
            len_chk_en <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == 1'b0) max_size   <= cfg_wdata;
            else                  len_chk_en <= cfg_wdata[0];
        end
    end

    AST_CEIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(max_size)); // R7

    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(len_chk_en)); // R6

endmodule

// File: rtl/rxerr_classifier.sv
module rxerr_classifier
    import rxerr_pkg::*;
#(
    parameter int NLANE       = 4,
    parameter int SIZE_W      = 16,
    parameter int MAX_DEFAULT = 1518,
    localparam int EW         = $clog2(NLANE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [8*NLANE-1:0] in_data,
    input  logic [NLANE-1:0]   in_ctl,
    input  logic [EW-1:0]      in_empty,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [SIZE_W-1:0]  cfg_wdata,
    output logic               rpt_valid,
    output logic [5:0]         rpt_err,
    output logic               rpt_fcs_err
);

    rx_state_e state, state_nx;

    logic [SIZE_W-1:0] cnt_q, base_cnt, size_nx, paylen;
    logic [SIZE_W:0]   sum;
    logic [31:0]       crc_q, base_crc, crc_nx;
    logic [15:0]       lt_q, base_lt, lt_nx;
    logic              mal_q, base_mal, lane_mal, mal_nx;
    logic [EW:0]       nbytes;
    logic [NLANE-1:0]  lane_en;
    logic              start, active, closing;
    logic [SIZE_W-1:0] max_size;
    logic              len_chk_en;
    logic              crc_bad, runt, too_long, plen_bad, frame_ok;

    rxerr_cfg #(.SIZE_W(SIZE_W), .MAX_DEFAULT(MAX_DEFAULT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .max_size(max_size), .len_chk_en(len_chk_en)
    );

    assign start   = in_valid && in_sop;
    assign active  = in_valid && (in_sop || state == S_FRAME);
    assign closing = active && in_eop;

    assign base_cnt = start ? '0 : cnt_q;
    assign base_crc = start ? '1 : crc_q;
    assign base_lt  = start ? '0 : lt_q;
    assign base_mal = start ? 1'b0 : mal_q;

    assign nbytes = in_eop ? ((EW+1)'(NLANE) - {1'b0, in_empty}) : (EW+1)'(NLANE);

    generate
        for (genvar l = 0; l < NLANE; l++) begin : g_en
            assign lane_en[l] = (EW+1)'(l) < nbytes;
        end
    endgenerate

    assign sum     = {1'b0, base_cnt} + (SIZE_W+1)'(nbytes);
    assign size_nx = sum[SIZE_W] ? '1 : sum[SIZE_W-1:0];

    rxerr_crc #(.NLANE(NLANE)) u_crc (
        .crc_in(base_crc), .data(in_data), .lane_en(lane_en), .crc_out(crc_nx)
    );

    rxerr_lanes #(.NLANE(NLANE), .SIZE_W(SIZE_W)) u_lanes (
        .base_cnt(base_cnt), .data(in_data), .ctl(in_ctl), .lane_en(lane_en),
        .lt_in(base_lt), .lt_out(lt_nx), .bad_ctl(lane_mal)
    );

    assign mal_nx = base_mal | lane_mal;

    // frame verdicts on the closing beat
    assign paylen   = size_nx - SIZE_W'(HDR_FCS_BYTES);
    assign crc_bad  = crc_nx != CRC_GOOD_REG;
    assign runt     = size_nx < SIZE_W'(MIN_FRAME);
    assign too_long = size_nx > max_size;
    assign frame_ok = size_nx > SIZE_W'(RUNT_MAX);
    always_comb begin
        plen_bad = 1'b0;
        if (len_chk_en && lt_nx < 16'(LEN_TYPE_LIMIT)) begin
            if (size_nx < SIZE_W'(HDR_FCS_BYTES))   plen_bad = 1'b1;
            else if (lt_nx >= 16'(MIN_PAYLOAD))     plen_bad = 32'(paylen) != 32'(lt_nx);
            else                                    plen_bad = size_nx != SIZE_W'(MIN_FRAME);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start && !in_eop)   state_nx = S_FRAME;
            S_FRAME: if (in_valid && in_eop) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state and frame accumulators
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt_q <= '0;
            crc_q <= '1;
            lt_q  <= '0;
            mal_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (active) begin
                cnt_q <= size_nx;
                crc_q <= crc_nx;
                lt_q  <= lt_nx;
                mal_q <= mal_nx;
            end
        end
    end

    // report outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_valid   <= 1'b0;
            rpt_err     <= '0;
            rpt_fcs_err <= 1'b0;
        end else begin
            rpt_valid <= closing && frame_ok;
            if (closing) begin
                rpt_err              <= '0;
                rpt_err[EB_CTL]      <= mal_nx;
                rpt_err[EB_CRC]      <= crc_bad | runt;
                rpt_err[EB_RUNT]     <= runt;
                rpt_err[EB_LONG]     <= too_long;
                rpt_err[EB_PLEN]     <= plen_bad;
                rpt_fcs_err          <= crc_bad | runt;
            end
        end
    end

    AST_RPT_FOLLOWS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> $past(in_valid && in_eop)); // R1

    AST_IDLE_BEAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !in_sop) |=> !rpt_valid); // R1

    AST_PLEN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_err[EB_PLEN]) |-> $past(len_chk_en)); // R6

    AST_RUNT_FLAGS_FCS: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_err[EB_RUNT]) |-> rpt_fcs_err); // R4

    AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> !rpt_err[5]); // R8

endmodule

// File: tb/rxerr_classifier_test.sv
`timescale 1ns/1ps
module rxerr_classifier_test;

    localparam int NLANE = 4;
    localparam int SW    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [8*NLANE-1:0] in_data = '0;
    logic [NLANE-1:0] in_ctl = '0;
    logic [1:0]       in_empty = '0;
    logic             cfg_we = 1'b0, cfg_addr = 1'b0;
    logic [SW-1:0]    cfg_wdata = '0;
    logic             rpt_valid, rpt_fcs_err;
    logic [5:0]       rpt_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit b_en = 0;
    int b_max = 1518;

    logic [7:0] fb   [0:2047];
    bit         fctl [0:2047];

    always #10 clk = ~clk;

    rxerr_classifier #(.NLANE(NLANE), .SIZE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_ctl(in_ctl), .in_empty(in_empty), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rpt_valid(rpt_valid),
        .rpt_err(rpt_err), .rpt_fcs_err(rpt_fcs_err)
    );

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input bit addr, input int val);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = SW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr) b_en = val[0]; else b_max = val;
    endtask

    task automatic build(input int len, input logic [15:0] lt, input bit bad,
                         input int cpos, input logic [7:0] ccode);
        logic [31:0] c;
        c = '1;
        for (int i = 0; i < len; i++) fctl[i] = 0;
        for (int i = 0; i < len - 4; i++) begin
            if (i == 12)        fb[i] = lt[15:8];
            else if (i == 13)   fb[i] = lt[7:0];
            else if (i == cpos) fb[i] = ccode;
            else                fb[i] = 8'(i * 13 + 5);
            c = crc_step(c, fb[i]);
        end
        c = ~c;
        for (int k = 0; k < 4; k++) fb[len - 4 + k] = c[8*k +: 8];
        if (bad) fb[len - 1] = fb[len - 1] ^ 8'h5A;
        if (cpos >= 0) fctl[cpos] = 1;
    endtask

    task automatic drive(input int len);
        int nb;
        nb = (len + NLANE - 1) / NLANE;
        for (int b = 0; b < nb; b++) begin
            in_valid = 1'b1;
            in_sop   = (b == 0);
            in_eop   = (b == nb - 1);
            in_empty = in_eop ? 2'(NLANE * nb - len) : 2'd0;
            for (int l = 0; l < NLANE; l++) begin
                int p;
                p = b * NLANE + l;
                in_data[8*l +: 8] = (p < len) ? fb[p] : 8'h00;
                in_ctl[l]         = (p < len) ? fctl[p] : 1'b0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_ctl = '0;
    endtask

    // one frame: build, send, compare the report against the requirements
    task automatic run_frame(input int len, input logic [15:0] lt, input bit bad,
                             input int cpos, input logic [7:0] ccode, input string req);
        bit runt, crcb, lng, plen, mal;
        logic [6:0] exp;
        build(len, lt, bad, cpos, ccode);
        runt = (len >= 9) && (len <= 63);
        crcb = bad || runt;
        lng  = len > b_max;
        mal  = (cpos >= 0) && (ccode != 8'hFD);
        plen = 0;
        if (b_en && lt < 16'd1536) begin
            if (len < 18)       plen = 1;
            else if (lt >= 46)  plen = (len - 18) != int'(lt);
            else                plen = len != 64;
        end
        exp = {crcb, 1'b0, plen, lng, runt, crcb, mal};
        drive(len);
        check(32'(rpt_valid), 32'(len > 8), {req, " report strobe"});
        if (len > 8) check(32'({rpt_fcs_err, rpt_err}), 32'(exp), {req, " error code"});
        @(negedge clk);
        check(32'(rpt_valid), 32'd0, "R1 single pulse");
    endtask

    task automatic t_reset;
        check(32'({rpt_valid, rpt_fcs_err, rpt_err}), 32'd0, "R1 R8 reset state");
    endtask

    task automatic t_stray_beats;
        for (int b = 0; b < 3; b++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (b == 2); in_empty = 2'd0;
            in_data = 32'h0102_0304;
            @(negedge clk);
        end
        in_valid = 1'b0; in_eop = 1'b0;
        check(32'(rpt_valid), 32'd0, "R1 beats outside a frame");
        @(negedge clk);
    endtask

    task automatic t_restart;
        build(64, 16'h0800, 1'b1, 20, 8'h07);
        for (int b = 0; b < 3; b++) begin
            in_valid = 1'b1; in_sop = (b == 0); in_eop = 1'b0; in_empty = 2'd0;
            for (int l = 0; l < NLANE; l++) begin
                in_data[8*l +: 8] = fb[b*NLANE + l];
                in_ctl[l] = 1'b1;
                if (l == 0) in_data[7:0] = 8'h07;
            end
            @(negedge clk);
        end
        in_ctl = '0;
        run_frame(70, 16'h0800, 0, -1, 8'h00, "R9 restart after partial");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_frame(64,   16'h0800, 0, -1, 8'h00, "R3 R8 good 64");
        run_frame(65,   16'h0800, 0, -1, 8'h00, "R10 empty 3");
        run_frame(66,   16'h0800, 0, -1, 8'h00, "R10 empty 2");
        run_frame(67,   16'h0800, 0, -1, 8'h00, "R10 empty 1");
        run_frame(100,  16'h0800, 1, -1, 8'h00, "R3 bad FCS");
        run_frame(40,   16'h0800, 0, -1, 8'h00, "R4 short 40");
        run_frame(63,   16'h0800, 0, -1, 8'h00, "R4 short 63");
        run_frame(9,    16'h0800, 0, -1, 8'h00, "R4 short 9");
        run_frame(8,    16'h0800, 0, -1, 8'h00, "R5 fragment 8");
        run_frame(5,    16'h0800, 0, -1, 8'h00, "R5 fragment 5");
        run_frame(1518, 16'h0800, 0, -1, 8'h00, "R7 at ceiling");
        run_frame(1519, 16'h0800, 0, -1, 8'h00, "R7 over ceiling");
        cfg_write(1'b0, 100);
        run_frame(100,  16'h0800, 0, -1, 8'h00, "R7 programmed ceiling");
        run_frame(101,  16'h0800, 0, -1, 8'h00, "R7 over programmed");
        cfg_write(1'b0, 1518);
        run_frame(80,   16'h0800, 0, 30, 8'h07, "R2 bad control");
        run_frame(80,   16'h0800, 0, 31, 8'hFD, "R2 terminate tolerated");
        run_frame(64,   16'd100,  0, -1, 8'h00, "R6 disabled");
        cfg_write(1'b1, 1);
        run_frame(64,   16'd46,   0, -1, 8'h00, "R6 exact 46");
        run_frame(64,   16'd20,   0, -1, 8'h00, "R6 padded");
        run_frame(70,   16'd20,   0, -1, 8'h00, "R6 short field bad pad");
        run_frame(64,   16'd100,  0, -1, 8'h00, "R6 mismatch");
        run_frame(118,  16'd100,  0, -1, 8'h00, "R6 match 100");
        run_frame(64,   16'd1536, 0, -1, 8'h00, "R6 type field");
        run_frame(12,   16'd0,    0, -1, 8'h00, "R6 R4 tiny");
        cfg_write(1'b1, 0);
        t_stray_beats();
        t_restart();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule